// File: doc/BRIEF.md
# Byte-Timed Square Wave Generator

This block drives a single output pin with a square wave whose every half-period is set separately. The half-periods come as 8-bit delay counts packed four to a 32-bit word. Words enter through a valid/ready handshake into a small FIFO of words. Each count sets the length of one output level, and the levels of a word run high, low, high, low, so one word covers two full output cycles. A level of count N lasts N plus a fixed overhead of clock cycles. The generator runs directly on the system clock with no prescaler.

An upstream producer computes the counts, for example by carrying a fractional error from one half-period to the next to hit a frequency between the integer steps, and streams them in. An enable input starts and stops the output. If the FIFO runs dry when a new word is needed, the generator holds the pin and raises an underrun flag until the next word arrives.

Top module: `byteTimedSquareGen`

## Requirements
- R1: After reset `pinOut` is 0, `underrun` is 0 and `inReady` is 1.
- R2: The counts of a word are used most significant byte first (bits 31:24, then 23:16, 15:8, 7:0), and the levels they time are high, low, high, low in that order.
- R3: A level timed by count N lasts exactly N+5 clock cycles, including N=0 (5 cycles) and N=255 (260 cycles).
- R4: The FIFO holds 8 words, and `inReady` is 0 while it holds 8. A word leaves the FIFO only at the clock edge where its first (high) level begins, and `pinOut` is 1 after that edge.
- R5: While `enable` is 0, no word leaves the FIFO, and `pinOut` is 0 from the clock edge after `enable` is seen low. Any unused counts of the current word are dropped, and the next enable starts with the most significant byte of a new word, at a high level.
- R6: When the last low level of a word ends and the FIFO is empty, `pinOut` stays low and `underrun` is 1 until a word is present. At the next clock edge `pinOut` goes high and `underrun` goes to 0.
- R7: Waiting for the first word after enable, or after a stop, is not an underrun: `underrun` stays 0 and `pinOut` stays 0.
- R8: When the next word is already in the FIFO, its first high level begins in the same cycle as the previous word's last low level ends, with no extra cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all levels are timed in its cycles |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the generator when 1; stops it and drives the pin low when 0 |
| inValid | input | 1 | Producer has a word on `inData` |
| inData | input | 32 | Four packed delay counts, most significant byte first |
| inReady | output | 1 | FIFO can take a word this cycle |
| pinOut | output | 1 | Square wave output |
| underrun | output | 1 | Generator is stalled waiting for a word |

## Verification
The bench builds the block with its default parameters: 8-bit counts, four counts per word, an 8-word FIFO and an overhead of 5 cycles. With these values the 260-cycle longest level and a completely full FIFO are both reached in a few hundred cycles. That lets one short run cover the two count extremes, back-pressure on the handshake, a stall in the middle of a stream, and a stop that drops part of a word. A scoreboard measures every completed level against the lengths and polarities predicted from the pushed words.

// File: rtl/sqgenPkg.sv
package sqgenPkg;

  // Strobes from the control FSM to the datapath; at most one is set per cycle.
  typedef struct packed {
    logic clear;      // stop: pin low, counter and word cleared
    logic loadWord;   // start a new word with its top byte, pin high
    logic loadNext;   // move to the next byte of the held word, toggle pin
    logic countDown;  // current level still running
  } sqgenStrobes_t;

endpackage

// File: rtl/wordFifo.sv
module wordFifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushValid,
  input  logic [WIDTH-1:0] pushData,
  output logic             pushReady,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic             empty
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [CNT_W-1:0] count;
  logic             doPush;
  logic             doPop;

  assign pushReady = (count != FULL_CNT);
  assign empty     = (count == '0);
  assign doPush    = pushValid && pushReady;
  assign doPop     = pop && !empty;
  assign headData  = mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) begin
        wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      end
      if (doPop) begin
        rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      end
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) begin
      mem[wrPtr] <= pushData;
    end
  end

endmodule

// File: rtl/sqgenCtrl.sv
module sqgenCtrl
  import sqgenPkg::*;
#(
  parameter int BYTES_PER_WORD = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  input  logic          levelDone,
  input  logic          fifoEmpty,
  output sqgenStrobes_t strobes,
  output logic          fifoPop,
  output logic          underrun
);

  localparam int IDX_W = (BYTES_PER_WORD > 1) ? $clog2(BYTES_PER_WORD) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTES_PER_WORD - 1);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_STALL
  } ctrlState_t;

  ctrlState_t state;
  ctrlState_t nextState;
  logic [IDX_W-1:0] byteIdx;

  always_comb begin
    strobes   = '0;
    fifoPop   = 1'b0;
    nextState = state;
    if (!enable) begin
      strobes.clear = 1'b1;
      nextState     = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE, ST_STALL: begin
          if (!fifoEmpty) begin
            strobes.loadWord = 1'b1;
            fifoPop          = 1'b1;
            nextState        = ST_RUN;
          end
        end
        ST_RUN: begin
          if (!levelDone) begin
            strobes.countDown = 1'b1;
          end else if (byteIdx != LAST_IDX) begin
            strobes.loadNext = 1'b1;
          end else if (!fifoEmpty) begin
            strobes.loadWord = 1'b1;
            fifoPop          = 1'b1;
          end else begin
            nextState = ST_STALL;
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      byteIdx <= '0;
    end else begin
      state <= nextState;
      if (strobes.clear || strobes.loadWord) begin
        byteIdx <= '0;
      end else if (strobes.loadNext) begin
        byteIdx <= byteIdx + 1'b1;
      end
    end
  end

  assign underrun = (state == ST_STALL);

endmodule

// File: rtl/sqgenDatapath.sv
module sqgenDatapath
  import sqgenPkg::*;
#(
  parameter int COUNT_W        = 8,
  parameter int BYTES_PER_WORD = 4,
  parameter int OVERHEAD       = 5
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  sqgenStrobes_t                       strobes,
  input  logic [COUNT_W*BYTES_PER_WORD-1:0]   headWord,
  output logic                                pinOut,
  output logic                                levelDone
);

  localparam int WORD_W = COUNT_W * BYTES_PER_WORD;
  localparam int CTR_W  = $clog2((2 ** COUNT_W) + OVERHEAD);
  localparam logic [CTR_W-1:0] LOAD_BIAS = CTR_W'(OVERHEAD - 1);

  logic [WORD_W-1:0] shiftReg;
  logic [CTR_W-1:0]  counter;
  logic [COUNT_W-1:0] headTop;
  logic [COUNT_W-1:0] heldTop;

  assign headTop   = headWord[WORD_W-1 -: COUNT_W];
  assign heldTop   = shiftReg[WORD_W-1 -: COUNT_W];
  assign levelDone = (counter == '0);

  function automatic logic [CTR_W-1:0] levelLoad(input logic [COUNT_W-1:0] cnt);
    return {{(CTR_W - COUNT_W){1'b0}}, cnt} + LOAD_BIAS;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      counter  <= '0;
      pinOut   <= 1'b0;
    end else if (strobes.clear) begin
      shiftReg <= '0;
      counter  <= '0;
      pinOut   <= 1'b0;
    end else if (strobes.loadWord) begin
      shiftReg <= headWord << COUNT_W;
      counter  <= levelLoad(headTop);
      pinOut   <= 1'b1;
    end else if (strobes.loadNext) begin
      shiftReg <= shiftReg << COUNT_W;
      counter  <= levelLoad(heldTop);
      pinOut   <= ~pinOut;
    end else if (strobes.countDown) begin
      counter <= counter - 1'b1;
    end
  end

endmodule

// File: rtl/byteTimedSquareGen.sv
module byteTimedSquareGen
  import sqgenPkg::*;
#(
  parameter int COUNT_W        = 8,
  parameter int BYTES_PER_WORD = 4,
  parameter int FIFO_DEPTH     = 8,
  parameter int OVERHEAD       = 5
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              enable,
  input  logic                              inValid,
  input  logic [COUNT_W*BYTES_PER_WORD-1:0] inData,
  output logic                              inReady,
  output logic                              pinOut,
  output logic                              underrun
);

  localparam int WORD_W = COUNT_W * BYTES_PER_WORD;

  sqgenStrobes_t     strobes;
  logic              fifoPop;
  logic              fifoEmpty;
  logic              levelDone;
  logic [WORD_W-1:0] headWord;

  wordFifo #(
    .WIDTH (WORD_W),
    .DEPTH (FIFO_DEPTH)
  ) u_fifo (
    .clk       (clk),
    .rstN      (rstN),
    .pushValid (inValid),
    .pushData  (inData),
    .pushReady (inReady),
    .pop       (fifoPop),
    .headData  (headWord),
    .empty     (fifoEmpty)
  );

  sqgenCtrl #(
    .BYTES_PER_WORD (BYTES_PER_WORD)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .levelDone (levelDone),
    .fifoEmpty (fifoEmpty),
    .strobes   (strobes),
    .fifoPop   (fifoPop),
    .underrun  (underrun)
  );

  sqgenDatapath #(
    .COUNT_W        (COUNT_W),
    .BYTES_PER_WORD (BYTES_PER_WORD),
    .OVERHEAD       (OVERHEAD)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .headWord  (headWord),
    .pinOut    (pinOut),
    .levelDone (levelDone)
  );

endmodule

// File: rtl/sqgenChecker.sv
module sqgenChecker #(
  parameter int OVERHEAD = 5
) (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic inReady,
  input logic pinOut,
  input logic underrun,
  input logic fifoPop,
  input logic fifoEmpty
);

  logic        prevPin;
  logic [15:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevPin <= 1'b0;
      runLen  <= '0;
    end else begin
      prevPin <= pinOut;
      if (pinOut != prevPin) begin
        runLen <= 16'd1;
      end else if (runLen != 16'hFFFF) begin
        runLen <= runLen + 1'b1;
      end
    end
  end

  // R4
  pop_start_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |=> pinOut);

  // R4
  no_empty_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> (!fifoEmpty && inReady == inReady));

  // R5
  disabled_no_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !fifoPop);

  // R5
  disabled_pin_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !pinOut);

  // R6
  stall_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    underrun |-> !pinOut);

  // R6
  stall_from_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(underrun) |-> $past(fifoEmpty));

  // R6
  stall_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (underrun && !fifoEmpty) |=> !underrun);

  // R3
  min_high_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (prevPin && !pinOut && $past(enable)) |-> (runLen >= 16'(OVERHEAD)));

endmodule

bind byteTimedSquareGen sqgenChecker #(
  .OVERHEAD (OVERHEAD)
) u_sqgenChecker (
  .clk       (clk),
  .rstN      (rstN),
  .enable    (enable),
  .inReady   (inReady),
  .pinOut    (pinOut),
  .underrun  (underrun),
  .fifoPop   (fifoPop),
  .fifoEmpty (fifoEmpty)
);

// File: tb/test_byteTimedSquareGen.sv
`timescale 1ns/1ps
module test_byteTimedSquareGen;

  localparam int OVH = 5;

  typedef struct {
    bit level;
    int len;
    bit atLeast;
  } levelExp_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inData = '0;
  logic        inReady;
  logic        pinOut;
  logic        underrun;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  levelExp_t expQ[$];

  always #4 clk = ~clk;

  byteTimedSquareGen i_byteTimedSquareGen (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .inValid  (inValid),
    .inData   (inData),
    .inReady  (inReady),
    .pinOut   (pinOut),
    .underrun (underrun)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic endRun();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  // Push a word; predicted levels are queued in the order R2 defines.
  task automatic pushWord(input logic [31:0] w, input bit lastStalls);
    bit acc;
    inValid = 1'b1;
    inData  = w;
    do begin
      acc = inReady;
      if (acc) begin
        for (int b = 3; b >= 0; b--) begin
          levelExp_t e;
          e.level   = (b % 2 == 1);
          e.len     = int'(w[b*8 +: 8]) + OVH;
          e.atLeast = (b == 0) && lastStalls;
          expQ.push_back(e);
        end
      end
      @(posedge clk);
      #1;
    end while (!acc);
    inValid = 1'b0;
  endtask

  task automatic waitUnderrun(input string req);
    int n = 0;
    while (!underrun && n < 3000) begin
      step(1);
      n++;
    end
    check(underrun == 1'b1, req, int'(underrun), 1);
  endtask

  task automatic dropStalledTail(input string req);
    check(expQ.size() == 1 && expQ[0].atLeast, req, expQ.size(), 1);
    expQ.delete();
  endtask

  // Monitor: measures each completed level and compares it with the scoreboard.
  bit prevPin = 1'b0;
  bit armed   = 1'b0;
  int runLen  = 0;
  always @(negedge clk) begin
    if (!rstN || !enable) begin
      armed   = 1'b0;
      prevPin = pinOut;
      runLen  = 1;
    end else if (pinOut == prevPin) begin
      runLen++;
    end else begin
      if (armed) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R2 unexpected level", runLen, 0);
        end else begin
          levelExp_t e;
          e = expQ.pop_front();
          check(e.level == prevPin, "R2 level polarity", int'(prevPin), int'(e.level));
          if (e.atLeast)
            check(runLen >= e.len, "R6 stalled level length", runLen, e.len);
          else
            check(runLen == e.len, "R3 R8 level length", runLen, e.len);
        end
      end
      armed   = 1'b1;
      prevPin = pinOut;
      runLen  = 1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    endRun();
  end

  initial begin
    step(3);
    // R1 reset state
    check(pinOut == 1'b0, "R1 pinOut", int'(pinOut), 0);
    check(underrun == 1'b0, "R1 underrun", int'(underrun), 0);
    check(inReady == 1'b1, "R1 inReady", int'(inReady), 1);
    rstN = 1'b1;
    step(2);

    // R7 waiting for the first word is not an underrun
    enable = 1'b1;
    step(20);
    check(underrun == 1'b0, "R7 underrun idle", int'(underrun), 0);
    check(pinOut == 1'b0, "R7 pin idle", int'(pinOut), 0);

    // R2 R3 R8 stream with both count extremes, then a mid-stream stall
    pushWord(32'h01020304, 1'b0);
    pushWord(32'h00FF0700, 1'b0);
    pushWord(32'h10203040, 1'b0);
    pushWord(32'h05060708, 1'b1);
    waitUnderrun("R6 stall raised");
    check(pinOut == 1'b0, "R6 pin held low", int'(pinOut), 0);
    step(7);
    check(underrun == 1'b1 && pinOut == 1'b0, "R6 stall held", int'(pinOut), 0);
    pushWord(32'h02030405, 1'b1);
    step(1);
    check(underrun == 1'b0, "R6 underrun released", int'(underrun), 0);
    check(pinOut == 1'b1, "R6 pin high on resume", int'(pinOut), 1);
    waitUnderrun("R6 second stall");
    enable = 1'b0;
    step(2);
    check(pinOut == 1'b0 && underrun == 1'b0, "R5 stop clears", int'(underrun), 0);
    dropStalledTail("R5 tail");

    // R4 R5 fill FIFO while disabled; nothing is consumed
    for (int i = 0; i < 8; i++) pushWord(32'h00000000 + i, i == 7);
    check(inReady == 1'b0, "R4 full after 8", int'(inReady), 0);
    step(30);
    check(pinOut == 1'b0, "R5 no output when disabled", int'(pinOut), 0);
    check(inReady == 1'b0, "R5 no word consumed", int'(inReady), 0);
    enable = 1'b1;
    step(1);
    check(pinOut == 1'b1, "R4 pin high at pop", int'(pinOut), 1);
    check(inReady == 1'b1, "R4 one word popped", int'(inReady), 1);
    waitUnderrun("R4 drain");
    enable = 1'b0;
    step(2);
    dropStalledTail("R4 tail");

    // R5 stop in the middle of a word drops its remainder
    enable = 1'b1;
    pushWord(32'hFFFF0101, 1'b0);
    step(50);
    check(pinOut == 1'b1, "R5 mid level high", int'(pinOut), 1);
    enable = 1'b0;
    step(1);
    check(pinOut == 1'b0, "R5 pin low after stop", int'(pinOut), 0);
    expQ.delete();
    step(3);
    enable = 1'b1;
    step(10);
    check(underrun == 1'b0 && pinOut == 1'b0, "R7 no underrun after stop", int'(underrun), 0);
    pushWord(32'h03040506, 1'b1);
    waitUnderrun("R5 restart word");
    enable = 1'b0;
    step(2);
    dropStalledTail("R5 restart tail");

    step(5);
    endRun();
  end

endmodule